// File: doc/BRIEF.md
# LCD Controller Register Bank

This block is the software-visible register bank of a simple LCD controller. A plain single-cycle bus with a byte address, write data, a write strobe, a read strobe and a combinational read-data path reaches six 32-bit registers: control, three timing words, a read-only status word and a subpanel word. Some fields are re-packed on read-back, and several registers return fixed constant bits ORed into their contents.

Three status flags come from an external frame engine. Each flag is set by a one-cycle pulse and stays set until reset. The flags and a two-bit mask from the control register combine into one level interrupt. The panel enable is held by a two-state machine with the states PANEL_OFF and PANEL_ON. The transition "switch on" (PANEL_OFF to PANEL_ON) happens on a control write with bit 0 high. The transition "switch off" (PANEL_ON to PANEL_OFF) happens on a control write with bit 0 low. Either transition emits a one-cycle pulse that tells the frame engine to start or stop. An access to an unmapped address emits a one-cycle debug pulse.

Top module: `lcd_regbank`

## Requirements
- R1: After reset, the registers read as follows: control 0xFE000C34, timing0 0x0000000F, timing1 0x00000000, timing2 0xFC000000, status 0x00000000 and subpanel 0x00000000. After reset the interrupt, the enable pulse and the debug pulse are all low.
- R2: A write to the control register (address 0x00) takes the palette mode from bits 21:20, the TFT bit from bit 7, the interrupt mask from bits 4:3, the mono bit from bit 1 and the enable from bit 0. It keeps the other bits of the write data under the mask 0x01CFF300. A read of the control register returns the OR of the following: 0xFE000C34, the kept bits, TFT at bit 23 and at bit 7, the palette mode at bits 21:20, the mask at bits 4:3, mono at bit 1 and the enable at bit 0.
- R3: Timing0 (address 0x04) stores bits 9:0 of a write as the width minus one and stores bits 31:10 unchanged. A read returns the stored value ORed with 0x0000000F.
- R4: Timing1 (address 0x08) stores bits 9:0 of a write as the height minus one and stores bits 31:10 unchanged. A read returns exactly the value written.
- R5: Timing2 (address 0x0C) stores the whole word. A read returns it ORed with 0xFC000000.
- R6: The status register (address 0x10) is read-only, and a write to it changes nothing. A read returns the palette-loaded flag at bit 6, the sync-error flag at bit 2 and the frame-done flag at bit 0, with all other bits zero.
- R7: A write to the subpanel register (address 0x14) is ANDed with 0xA1FFFFFF before it is stored. A read returns the stored value.
- R8: The interrupt is high when frame-done is set and mask bit 0 (control bit 3) is set, when palette-loaded is set and mask bit 1 (control bit 4) is set, or when sync-error is set whatever the mask holds. In every other case it is low.
- R9: A one-cycle set pulse on a flag input makes that flag read as 1 from the next cycle onwards, and the flag stays set until reset.
- R10: A control write whose bit 0 differs from the current enable drives the enable-change output high for exactly the one cycle after the write. A control write with the same enable value produces no pulse.
- R11: A read or write at any address other than 0x00, 0x04, 0x08, 0x0C, 0x10 or 0x14 reads as zero and changes no register. It drives the debug pulse high for the one cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; read data is valid whenever the address is stable |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| frm_done_set_i | input | 1 | Set pulse for the frame-done flag |
| pal_done_set_i | input | 1 | Set pulse for the palette-loaded flag |
| sync_err_set_i | input | 1 | Set pulse for the sync-error flag |
| irq_o | output | 1 | Level interrupt |
| en_chg_o | output | 1 | One-cycle pulse when the panel enable changes |
| bad_addr_o | output | 1 | One-cycle debug pulse after an unmapped access |

## Verification
A flag set pulse from the frame engine can arrive in the same cycle as a bus write that changes the interrupt mask. It can also arrive in the same cycle as a write to the status register. The bench drives both events on the same clock edge. It then checks three things after that edge: the interrupt reflects the new mask and the new flag together, the flag reads as set, and the ignored status write did not clear it.

// File: rtl/lcd_regbank_pkg.sv
package lcd_regbank_pkg;

    localparam int DATA_W  = 32;
    localparam int FIELD_W = 10;
    localparam int HI_W    = DATA_W - FIELD_W;

    // register byte offsets
    localparam int OFF_CTRL = 'h00;
    localparam int OFF_TIM0 = 'h04;
    localparam int OFF_TIM1 = 'h08;
    localparam int OFF_TIM2 = 'h0C;
    localparam int OFF_STAT = 'h10;
    localparam int OFF_SUB  = 'h14;

    // constant and mask words
    localparam logic [DATA_W-1:0] CTRL_KEEP_MASK = 32'h01CF_F300;
    localparam logic [DATA_W-1:0] CTRL_FIXED     = 32'hFE00_0C34;
    localparam logic [DATA_W-1:0] TIM0_FIXED     = 32'h0000_000F;
    localparam logic [DATA_W-1:0] TIM2_FIXED     = 32'hFC00_0000;
    localparam logic [DATA_W-1:0] SUB_MASK       = 32'hA1FF_FFFF;

    // control field positions
    localparam int CB_EN    = 0;
    localparam int CB_MONO  = 1;
    localparam int CB_MASK  = 3;
    localparam int CB_TFT   = 7;
    localparam int CB_PLM   = 20;
    localparam int CB_TFT_H = 23;

    // status flag indices and read-back positions
    localparam int NUM_FLAGS = 3;
    localparam int FLG_FRAME = 0;
    localparam int FLG_PAL   = 1;
    localparam int FLG_SYNC  = 2;
    localparam int SB_FRAME  = 0;
    localparam int SB_SYNC   = 2;
    localparam int SB_PAL    = 6;

    typedef enum logic [2:0] {
        SEL_CTRL, SEL_TIM0, SEL_TIM1, SEL_TIM2, SEL_STAT, SEL_SUB, SEL_NONE
    } reg_sel_e;

    typedef enum logic {
        PANEL_OFF = 1'b0,
        PANEL_ON  = 1'b1
    } panel_state_e;

endpackage

// File: rtl/lcd_panel_fsm.sv
module lcd_panel_fsm
    import lcd_regbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_we,
    input  logic wr_en_bit,
    output logic panel_on,
    output logic en_chg_o
);

    panel_state_e state_q, state_d;
    logic         toggle;
    logic         pulse_q;

    always_comb begin
        state_d = state_q;
        toggle  = 1'b0;
        if (ctrl_we) begin
            unique case (state_q)
                PANEL_OFF: if (wr_en_bit) begin
                    state_d = PANEL_ON;
                    toggle  = 1'b1;
                end
                PANEL_ON: if (!wr_en_bit) begin
                    state_d = PANEL_OFF;
                    toggle  = 1'b1;
                end
                default: state_d = PANEL_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PANEL_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= toggle;
    end

    assign panel_on = (state_q == PANEL_ON);
    assign en_chg_o = pulse_q;

    // R10
    en_pulse_means_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_chg_o |-> (panel_on != $past(panel_on)));

    // R10
    same_enable_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && (wr_en_bit == panel_on)) |=> !en_chg_o);

endmodule

// File: rtl/lcd_status_irq.sv
module lcd_status_irq
    import lcd_regbank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_i,
    input  logic [1:0]           imask,
    output logic [NUM_FLAGS-1:0] flags_o,
    output logic                 irq_o
);

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_q <= 1'b0;
            else if (set_i[k]) flag_q <= 1'b1;
        end
        assign flags_o[k] = flag_q;

        // R9
        flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> flags_o[k]);

        // R9
        flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            flags_o[k] |=> flags_o[k]);
    end

    always_comb begin
        irq_o = 1'b0;
        if (flags_o[FLG_FRAME] && imask[0])     irq_o = 1'b1;
        else if (flags_o[FLG_PAL] && imask[1])  irq_o = 1'b1;
        else if (flags_o[FLG_SYNC])             irq_o = 1'b1;
    end

    // R8
    sync_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[FLG_SYNC] |=> irq_o);

endmodule

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
    import lcd_regbank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  reg_sel_e             sel,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 panel_on,
    input  logic [NUM_FLAGS-1:0] flags,
    output logic [1:0]           imask,
    output logic [DATA_W-1:0]    rdata
);

    logic [1:0]         plm_q;
    logic               tft_q;
    logic               mono_q;
    logic [1:0]         mask_q;
    logic [DATA_W-1:0]  keep_q;
    logic [HI_W-1:0]    t0_hi_q, t1_hi_q;
    logic [FIELD_W-1:0] width_m1_q, height_m1_q;
    logic [DATA_W-1:0]  t2_q, sub_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plm_q       <= '0;
            tft_q       <= 1'b0;
            mono_q      <= 1'b0;
            mask_q      <= '0;
            keep_q      <= '0;
            t0_hi_q     <= '0;
            width_m1_q  <= '0;
            t1_hi_q     <= '0;
            height_m1_q <= '0;
            t2_q        <= '0;
            sub_q       <= '0;
        end else if (we) begin
            unique case (sel)
                SEL_CTRL: begin
                    plm_q  <= wdata[CB_PLM +: 2];
                    tft_q  <= wdata[CB_TFT];
                    mask_q <= wdata[CB_MASK +: 2];
                    mono_q <= wdata[CB_MONO];
                    keep_q <= wdata & CTRL_KEEP_MASK;
                end
                SEL_TIM0: begin
                    t0_hi_q    <= wdata[DATA_W-1:FIELD_W];
                    width_m1_q <= wdata[FIELD_W-1:0];
                end
                SEL_TIM1: begin
                    t1_hi_q     <= wdata[DATA_W-1:FIELD_W];
                    height_m1_q <= wdata[FIELD_W-1:0];
                end
                SEL_TIM2: t2_q  <= wdata;
                SEL_SUB:  sub_q <= wdata & SUB_MASK;
                default: ;
            endcase
        end
    end

    assign imask = mask_q;

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_CTRL: rdata = CTRL_FIXED | keep_q
                            | (DATA_W'(tft_q)    << CB_TFT_H)
                            | (DATA_W'(plm_q)    << CB_PLM)
                            | (DATA_W'(tft_q)    << CB_TFT)
                            | (DATA_W'(mask_q)   << CB_MASK)
                            | (DATA_W'(mono_q)   << CB_MONO)
                            | (DATA_W'(panel_on) << CB_EN);
            SEL_TIM0: rdata = {t0_hi_q, width_m1_q} | TIM0_FIXED;
            SEL_TIM1: rdata = {t1_hi_q, height_m1_q};
            SEL_TIM2: rdata = t2_q | TIM2_FIXED;
            SEL_STAT: rdata = (DATA_W'(flags[FLG_PAL])   << SB_PAL)
                            | (DATA_W'(flags[FLG_SYNC])  << SB_SYNC)
                            | (DATA_W'(flags[FLG_FRAME]) << SB_FRAME);
            SEL_SUB:  rdata = sub_q;
            default:  rdata = '0;
        endcase
    end

    // R3
    width_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_TIM0) |=> (width_m1_q == $past(wdata[FIELD_W-1:0])));

    // R7
    sub_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_q & ~SUB_MASK) == '0);

endmodule

// File: rtl/lcd_regbank.sv
module lcd_regbank
    import lcd_regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    input  logic              frm_done_set_i,
    input  logic              pal_done_set_i,
    input  logic              sync_err_set_i,
    output logic              irq_o,
    output logic              en_chg_o,
    output logic              bad_addr_o
);

    reg_sel_e             sel;
    logic                 panel_on;
    logic [1:0]           imask;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_FLAGS-1:0] set_vec;
    logic                 bad_q;

    always_comb begin
        if      (bus_addr == ADDR_W'(OFF_CTRL)) sel = SEL_CTRL;
        else if (bus_addr == ADDR_W'(OFF_TIM0)) sel = SEL_TIM0;
        else if (bus_addr == ADDR_W'(OFF_TIM1)) sel = SEL_TIM1;
        else if (bus_addr == ADDR_W'(OFF_TIM2)) sel = SEL_TIM2;
        else if (bus_addr == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
        else if (bus_addr == ADDR_W'(OFF_SUB))  sel = SEL_SUB;
        else                                    sel = SEL_NONE;
    end

    always_comb begin
        set_vec            = '0;
        set_vec[FLG_FRAME] = frm_done_set_i;
        set_vec[FLG_PAL]   = pal_done_set_i;
        set_vec[FLG_SYNC]  = sync_err_set_i;
    end

    lcd_panel_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (bus_we && sel == SEL_CTRL),
        .wr_en_bit (bus_wdata[CB_EN]),
        .panel_on  (panel_on),
        .en_chg_o  (en_chg_o)
    );

    lcd_status_irq u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .imask   (imask),
        .flags_o (flags),
        .irq_o   (irq_o)
    );

    lcd_cfg_regs u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bus_we),
        .sel      (sel),
        .wdata    (bus_wdata),
        .panel_on (panel_on),
        .flags    (flags),
        .imask    (imask),
        .rdata    (bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) bad_q <= 1'b0;
        else        bad_q <= (bus_we || bus_re) && (sel == SEL_NONE);
    end

    assign bad_addr_o = bad_q;

    // R11
    unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (bus_rdata == '0));

    // R11
    bad_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_addr_o |-> $past((bus_we || bus_re) && sel == SEL_NONE));

    // R8
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flags != '0));

endmodule

// File: tb/lcd_regbank_tb.sv
`timescale 1ns/1ps
module lcd_regbank_tb_top;

    localparam int ADDR_W = 8;
    localparam int NVEC   = 11;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] bus_addr;
    logic [31:0]       bus_wdata;
    logic              bus_we, bus_re;
    logic [31:0]       bus_rdata;
    logic              frm_set, pal_set, sync_set;
    logic              irq_o, en_chg_o, bad_addr_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lcd_regbank #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .frm_done_set_i(frm_set), .pal_done_set_i(pal_set), .sync_err_set_i(sync_set),
        .irq_o(irq_o), .en_chg_o(en_chg_o), .bad_addr_o(bad_addr_o)
    );

    // {address, write data, expected read-back}
    localparam logic [71:0] VEC [NVEC] = '{
        {8'h04, 32'h1234_5678, 32'h1234_567F},  // R3
        {8'h04, 32'h0000_0400, 32'h0000_040F},  // R3
        {8'h08, 32'hCAFE_0123, 32'hCAFE_0123},  // R4
        {8'h0C, 32'h0123_4567, 32'hFD23_4567},  // R5
        {8'h0C, 32'h0000_0000, 32'hFC00_0000},  // R5
        {8'h14, 32'hFFFF_FFFF, 32'hA1FF_FFFF},  // R7
        {8'h14, 32'h5E00_0001, 32'h0000_0001},  // R7
        {8'h00, 32'h0000_0000, 32'hFE00_0C34},  // R2
        {8'h00, 32'h0030_0012, 32'hFE30_0C36},  // R2
        {8'h10, 32'hFFFF_FFFF, 32'h0000_0000},  // R6
        {8'h18, 32'hFFFF_FFFF, 32'h0000_0000}   // R11
    };

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00:   return "R2";
            8'h04:   return "R3";
            8'h08:   return "R4";
            8'h0C:   return "R5";
            8'h10:   return "R6";
            8'h14:   return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
        frm_set = 1'b0; pal_set = 1'b0; sync_set = 1'b0;
        do_reset();

        // R1 reset values
        do_read(8'h00, rd); check("R1", rd, 32'hFE00_0C34);
        do_read(8'h04, rd); check("R1", rd, 32'h0000_000F);
        do_read(8'h08, rd); check("R1", rd, 32'h0000_0000);
        do_read(8'h0C, rd); check("R1", rd, 32'hFC00_0000);
        do_read(8'h10, rd); check("R1", rd, 32'h0000_0000);
        do_read(8'h14, rd); check("R1", rd, 32'h0000_0000);
        check("R1", {29'd0, irq_o, en_chg_o, bad_addr_o}, 32'd0);

        // vector table: write then read back
        for (int i = 0; i < NVEC; i++) begin
            do_write(VEC[i][71:64], VEC[i][63:32]);
            do_read(VEC[i][71:64], rd);
            check(tag_of(VEC[i][71:64]), rd, VEC[i][31:0]);
        end
        do_write(8'h00, 32'h0);

        // R10 enable change pulse
        do_write(8'h00, 32'h1);
        check("R10", {31'd0, en_chg_o}, 32'd1);
        @(negedge clk); check("R10", {31'd0, en_chg_o}, 32'd0);
        do_read(8'h00, rd); check("R2", rd, 32'hFE00_0C35);
        do_write(8'h00, 32'h1);
        check("R10", {31'd0, en_chg_o}, 32'd0);
        do_write(8'h00, 32'h0);
        check("R10", {31'd0, en_chg_o}, 32'd1);

        // R2 all-ones control word
        do_write(8'h00, 32'hFFFF_FFFF);
        check("R10", {31'd0, en_chg_o}, 32'd1);
        do_read(8'h00, rd); check("R2", rd, 32'hFFFF_FFBF);
        do_write(8'h00, 32'h0);

        // R8 / R9 interrupt and flags
        @(negedge clk); frm_set = 1'b1; @(negedge clk); frm_set = 1'b0;
        check("R8", {31'd0, irq_o}, 32'd0);
        do_read(8'h10, rd); check("R9", rd, 32'h0000_0001);
        do_write(8'h00, 32'h08);
        check("R8", {31'd0, irq_o}, 32'd1);
        do_write(8'h00, 32'h10);
        check("R8", {31'd0, irq_o}, 32'd0);
        @(negedge clk); pal_set = 1'b1; @(negedge clk); pal_set = 1'b0;
        check("R8", {31'd0, irq_o}, 32'd1);
        do_read(8'h10, rd); check("R6", rd, 32'h0000_0041);
        do_write(8'h00, 32'h0);
        check("R8", {31'd0, irq_o}, 32'd0);
        @(negedge clk); sync_set = 1'b1; @(negedge clk); sync_set = 1'b0;
        check("R8", {31'd0, irq_o}, 32'd1);
        do_read(8'h10, rd); check("R9", rd, 32'h0000_0045);
        do_write(8'h10, 32'h0);
        do_read(8'h10, rd); check("R6", rd, 32'h0000_0045);

        // same-cycle: mask write with flag set, status write with flag set
        do_reset();
        check("R1", {31'd0, irq_o}, 32'd0);
        @(negedge clk);
        bus_addr = 8'h00; bus_wdata = 32'h08; bus_we = 1'b1; frm_set = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; frm_set = 1'b0;
        check("R8", {31'd0, irq_o}, 32'd1);
        @(negedge clk);
        bus_addr = 8'h10; bus_wdata = 32'h0; bus_we = 1'b1; pal_set = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; pal_set = 1'b0;
        do_read(8'h10, rd); check("R6", rd, 32'h0000_0041);

        // R11 unmapped accesses
        do_write(8'h0C, 32'h0000_1111);
        do_write(8'h18, 32'hFFFF_FFFF);
        check("R11", {31'd0, bad_addr_o}, 32'd1);
        @(negedge clk); check("R11", {31'd0, bad_addr_o}, 32'd0);
        do_read(8'h0C, rd); check("R11", rd, 32'hFC00_1111);
        check("R11", {31'd0, bad_addr_o}, 32'd0);
        do_read(8'h02, rd); check("R11", rd, 32'h0);
        check("R11", {31'd0, bad_addr_o}, 32'd1);

        finish_run();
    end

endmodule